// File: doc/BRIEF.md
# Load-Ordering Snoop Violation Detector

This block keeps a small queue of in-flight loads, held in program order, and finds the loads whose early results have become unsafe. Loads enter the queue at the tail with their address. Each load is later marked complete by its queue index, and loads may complete in any order. A load that completes ahead of an older load has already passed its value on to dependent work, so it stays speculative until every older load has also completed. Completed loads leave the queue from the head, one per cycle, strictly in order.

When another agent writes a cache line, an invalidation snoop arrives with that line's address. Suppose the snoop hits a completed load that still has an older incomplete load in front of it. That load returned a value that the rest of the system now regards as stale, while an earlier load has not yet been ordered. The block raises a single-cycle clear request carrying the index of the offending load. In the same cycle it discards that entry and every younger one and moves the allocation point back to the cleared index, so the loads can be issued again. A snoop hit on a completed load with no older incomplete load is harmless and is ignored.

The queue depth must be a power of two. Addresses are compared on whole cache lines.

Top module: `ld_order_guard`

## Requirements
- R1: After reset the queue is empty: `alloc_ready_o` is 1, `alloc_idx_o` is 0, and `retire_valid_o` and `clear_o` are both 0.
- R2: Each accepted allocation takes the index shown on `alloc_idx_o`, and that index advances by one, modulo DEPTH, per accepted load. `alloc_ready_o` is 0 while DEPTH loads are held.
- R3: A completion for an index the queue does not hold has no effect. Loads retire in allocation order whatever their completion order, and `retire_idx_o` gives the index of the retiring load.
- R4: When the oldest held load is complete, `retire_valid_o` is 1 in that cycle and the load leaves at the clock edge. At most one load retires per cycle. A completion takes effect from the following cycle.
- R5: A snoop whose address matches a completed load on bits ADDR_W-1 down to LINE_OFF_W (the low 6 bits are ignored by default) raises `clear_o` in the same cycle, with that load's index on `clear_idx_o`. This happens only when an older held load is still incomplete.
- R6: A snoop hit on a completed load that has no older incomplete load does nothing. This includes the head load retiring in that same cycle.
- R7: A snoop that arrives in the same cycle as the completion of the matching load treats that load as incomplete and raises no clear.
- R8: When several completed loads qualify for one snoop, `clear_idx_o` names the oldest of them.
- R9: In a clear cycle no allocation is accepted (`alloc_ready_o` is 0). The cleared load and all younger loads are discarded, and the next allocation index equals the cleared index.
- R10: A snoop that matches no load, or matches only incomplete loads, raises no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | New load presented in program order |
| alloc_addr_i | input | ADDR_W | Address of the new load |
| alloc_ready_o | output | 1 | Allocation accepted this cycle if valid |
| alloc_idx_o | output | IDX_W | Queue index given to the next allocation |
| cmpl_valid_i | input | 1 | A load has received its data |
| cmpl_idx_i | input | IDX_W | Index of the completing load |
| snoop_valid_i | input | 1 | Invalidation snoop present |
| snoop_addr_i | input | ADDR_W | Address of the invalidated line |
| retire_valid_o | output | 1 | Oldest load retires this cycle |
| retire_idx_o | output | IDX_W | Index of the retiring load |
| clear_o | output | 1 | Ordering violation; squash from clear_idx_o onward |
| clear_idx_o | output | IDX_W | Index of the oldest violating load |

## Verification
The hardest situation to reach is a clear. It needs a completed younger load and an older incomplete load whose line addresses line up with a snoop, and the random traffic seldom produces several such loads for one snoop, or a snoop hit on the head while it retires. Directed sequences first fill the queue and place two loads on one shared line. They then complete the loads out of order and snoop that line, and also drive a snoop together with a completion of the same load. Random traffic then draws addresses from four lines with random offsets, which keeps snoop hits frequent. It aims most completions at loads the queue actually holds, so younger-complete and older-pending patterns keep forming.

// File: rtl/ldo_pkg.sv
package ldo_pkg;
  typedef struct packed {
    logic valid;
    logic done;
  } ent_state_t;
endpackage

// File: rtl/ldo_entry_array.sv
module ldo_entry_array
  import ldo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 26,
  parameter int IDX_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  alloc_we_i,
  input  logic [IDX_W-1:0]      alloc_idx_i,
  input  logic [TAG_W-1:0]      alloc_tag_i,
  input  logic                  cmpl_valid_i,
  input  logic [IDX_W-1:0]      cmpl_idx_i,
  input  logic [DEPTH-1:0]      squash_i,
  input  logic                  retire_i,
  input  logic [IDX_W-1:0]      retire_idx_i,
  output ent_state_t [DEPTH-1:0] state_o,
  output logic [DEPTH-1:0][TAG_W-1:0] tag_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic alloc_hit, cmpl_hit, retire_hit;
    assign alloc_hit  = alloc_we_i && (alloc_idx_i == IDX_W'(i));
    assign cmpl_hit   = cmpl_valid_i && (cmpl_idx_i == IDX_W'(i)) &&
                        state_o[i].valid && !squash_i[i];
    assign retire_hit = retire_i && (retire_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_o[i] <= '0;
      end else if (alloc_hit) begin
        state_o[i].valid <= 1'b1;
        state_o[i].done  <= 1'b0;
      end else begin
        if (squash_i[i] || retire_hit) state_o[i].valid <= 1'b0;
        if (cmpl_hit)                  state_o[i].done  <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        tag_o[i] <= '0;
      else if (alloc_hit) tag_o[i] <= alloc_tag_i;
    end
  end

endmodule

// File: rtl/ldo_hazard_scan.sv
module ldo_hazard_scan
  import ldo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 26,
  parameter int IDX_W = 3
) (
  input  ent_state_t [DEPTH-1:0]        state_i,
  input  logic [DEPTH-1:0][TAG_W-1:0]   tag_i,
  input  logic [IDX_W-1:0]              head_idx_i,
  input  logic                          retire_i,
  input  logic                          snoop_valid_i,
  input  logic [TAG_W-1:0]              snoop_tag_i,
  output logic                          clear_o,
  output logic [IDX_W-1:0]              clear_rel_o,
  output logic [DEPTH-1:0]              squash_o
);

  // age-ordered view: slot k is the k-th oldest position from head
  logic [DEPTH-1:0][IDX_W-1:0] a_idx;
  ent_state_t [DEPTH-1:0]      a_st;
  logic [DEPTH-1:0]            a_hit;
  logic [DEPTH-1:0]            pend_b;
  logic [DEPTH-1:0]            viol;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign a_idx[k] = head_idx_i + IDX_W'(k);
    assign a_st[k]  = state_i[a_idx[k]];
    assign a_hit[k] = snoop_valid_i && a_st[k].valid && a_st[k].done &&
                      (tag_i[a_idx[k]] == snoop_tag_i);
    if (k == 0) begin : g_first
      assign pend_b[k] = 1'b0;
      assign viol[k]   = a_hit[k] && pend_b[k] && !retire_i;
    end else begin : g_rest
      assign pend_b[k] = pend_b[k-1] || (a_st[k-1].valid && !a_st[k-1].done);
      assign viol[k]   = a_hit[k] && pend_b[k];
    end
  end

  always_comb begin
    clear_rel_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (viol[k]) clear_rel_o = IDX_W'(k);
    end
  end

  assign clear_o = |viol;

  for (genvar i = 0; i < DEPTH; i++) begin : g_sq
    logic [IDX_W-1:0] rel;
    assign rel         = IDX_W'(i) - head_idx_i;
    assign squash_o[i] = clear_o && (rel >= clear_rel_o);
  end

endmodule

// File: rtl/ld_order_guard.sv
module ld_order_guard
  import ldo_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int PTR_W     = IDX_W + 1,
  localparam int TAG_W     = ADDR_W - LINE_OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  output logic              alloc_ready_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              retire_valid_o,
  output logic [IDX_W-1:0]  retire_idx_o,
  output logic              clear_o,
  output logic [IDX_W-1:0]  clear_idx_o
);

  logic [PTR_W-1:0] head_q, tail_q, occ;
  logic [IDX_W-1:0] head_idx, clear_rel;
  logic             full, alloc_fire, retire;
  logic [DEPTH-1:0] squash;
  ent_state_t [DEPTH-1:0]        state;
  logic [DEPTH-1:0][TAG_W-1:0]   tags;
  logic unused_offsets;

  assign unused_offsets = ^{alloc_addr_i[LINE_OFF_W-1:0], snoop_addr_i[LINE_OFF_W-1:0]};

  assign head_idx   = head_q[IDX_W-1:0];
  assign occ        = tail_q - head_q;
  assign full       = (occ == PTR_W'(DEPTH));
  assign retire     = state[head_idx].valid && state[head_idx].done;

  assign alloc_ready_o  = !full && !clear_o;
  assign alloc_fire     = alloc_valid_i && alloc_ready_o;
  assign alloc_idx_o    = tail_q[IDX_W-1:0];
  assign retire_valid_o = retire;
  assign retire_idx_o   = head_idx;
  assign clear_idx_o    = head_idx + clear_rel;

  ldo_entry_array #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_we_i   (alloc_fire),
    .alloc_idx_i  (tail_q[IDX_W-1:0]),
    .alloc_tag_i  (alloc_addr_i[ADDR_W-1:LINE_OFF_W]),
    .cmpl_valid_i (cmpl_valid_i),
    .cmpl_idx_i   (cmpl_idx_i),
    .squash_i     (squash),
    .retire_i     (retire),
    .retire_idx_i (head_idx),
    .state_o      (state),
    .tag_o        (tags)
  );

  ldo_hazard_scan #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_scan (
    .state_i       (state),
    .tag_i         (tags),
    .head_idx_i    (head_idx),
    .retire_i      (retire),
    .snoop_valid_i (snoop_valid_i),
    .snoop_tag_i   (snoop_addr_i[ADDR_W-1:LINE_OFF_W]),
    .clear_o       (clear_o),
    .clear_rel_o   (clear_rel),
    .squash_o      (squash)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (retire) head_q <= head_q + PTR_W'(1);
      if (clear_o)         tail_q <= head_q + PTR_W'(clear_rel);
      else if (alloc_fire) tail_q <= tail_q + PTR_W'(1);
    end
  end

endmodule

// File: rtl/ld_order_guard_chk.sv
module ld_order_guard_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_ready_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             snoop_valid_i,
  input logic             retire_valid_o,
  input logic [IDX_W-1:0] retire_idx_o,
  input logic             clear_o,
  input logic [IDX_W-1:0] clear_idx_o,
  input logic [PTR_W-1:0] head_q,
  input logic [PTR_W-1:0] tail_q
);

  p_full_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PTR_W'(tail_q - head_q) == PTR_W'(DEPTH)) |-> !alloc_ready_o);

  p_retire_in_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(retire_valid_o) && retire_valid_o) |->
      (retire_idx_o == IDX_W'($past(retire_idx_o) + 1'b1)));

  p_no_retire_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_q == tail_q) |-> !retire_valid_o);

  p_clear_has_snoop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> snoop_valid_i);

  p_clear_not_head_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> (clear_idx_o != head_q[IDX_W-1:0]));

  p_clear_blocks_alloc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> !alloc_ready_o);

  p_tail_rewind_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (alloc_idx_o == $past(clear_idx_o)));

endmodule

bind ld_order_guard ld_order_guard_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_idx_o    (alloc_idx_o),
  .snoop_valid_i  (snoop_valid_i),
  .retire_valid_o (retire_valid_o),
  .retire_idx_o   (retire_idx_o),
  .clear_o        (clear_o),
  .clear_idx_o    (clear_idx_o),
  .head_q         (head_q),
  .tail_q         (tail_q)
);

// File: tb/ld_order_guard_bench.sv
module ld_order_guard_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [AW-1:0] alloc_addr = '0;
  logic          alloc_ready;
  logic [2:0]    alloc_idx;
  logic          cmpl_valid = 1'b0;
  logic [2:0]    cmpl_idx = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          retire_valid;
  logic [2:0]    retire_idx;
  logic          clear;
  logic [2:0]    clear_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // reference model
  int m_head = 0, m_tail = 0;
  bit m_done [DEPTH];
  int m_tag  [DEPTH];

  // outputs seen in the last step
  bit g_ready, g_retire, g_clear;
  int g_aidx, g_cidx;

  always #10 clk = ~clk;

  ld_order_guard u_ld_order_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_addr_i(alloc_addr),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .cmpl_valid_i(cmpl_valid), .cmpl_idx_i(cmpl_idx),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .retire_valid_o(retire_valid), .retire_idx_o(retire_idx),
    .clear_o(clear), .clear_idx_o(clear_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int line_of(input logic [AW-1:0] a);
    return int'(a >> 6);
  endfunction

  task automatic step(input bit av, input logic [AW-1:0] aa, input bit cv,
                      input int ci, input bit sv, input logic [AW-1:0] sa);
    int cnt, h, ck, rel;
    bit ret, clr, pend, exp_rdy;
    @(negedge clk);
    alloc_valid = av; alloc_addr = aa;
    cmpl_valid = cv;  cmpl_idx = 3'(ci);
    snoop_valid = sv; snoop_addr = sa;
    #1;
    cnt = (m_tail - m_head) & 15;
    h   = m_head & 7;
    ret = (cnt > 0) && m_done[h];
    clr = 0; ck = 0; pend = 0;
    for (int k = 0; k < cnt; k++) begin
      int idx;
      idx = (m_head + k) & 7;
      if (!clr && sv && m_done[idx] && m_tag[idx] == line_of(sa) && pend && !(ret && k == 0)) begin
        clr = 1; ck = k;
      end
      if (!m_done[idx]) pend = 1;
    end
    exp_rdy = (cnt < DEPTH) && !clr;
    check(alloc_ready == exp_rdy, "R2 alloc_ready", int'(alloc_ready), int'(exp_rdy));
    check(int'(alloc_idx) == (m_tail & 7), "R2 alloc_idx", int'(alloc_idx), m_tail & 7);
    check(retire_valid == ret, "R4 retire_valid", int'(retire_valid), int'(ret));
    if (ret) check(int'(retire_idx) == h, "R3 retire_idx", int'(retire_idx), h);
    check(clear == clr, "R5 clear", int'(clear), int'(clr));
    if (clr) check(int'(clear_idx) == ((m_head + ck) & 7), "R8 clear_idx",
                   int'(clear_idx), (m_head + ck) & 7);
    g_ready = alloc_ready; g_retire = retire_valid; g_clear = clear;
    g_aidx = int'(alloc_idx); g_cidx = int'(clear_idx);
    @(posedge clk);
    rel = (ci - m_head) & 7;
    if (cv && rel < cnt && !(clr && rel >= ck)) m_done[ci & 7] = 1;
    if (!clr && av && cnt < DEPTH) begin
      m_tag[m_tail & 7]  = line_of(aa);
      m_done[m_tail & 7] = 0;
      m_tail = (m_tail + 1) & 15;
    end
    if (clr) m_tail = (m_head + ck) & 15;
    if (ret) m_head = (m_head + 1) & 15;
  endtask

  task automatic idle();
    step(0, '0, 0, 0, 0, '0);
  endtask

  localparam logic [AW-1:0] LINE_A = 32'h0000_4000;

  function automatic logic [AW-1:0] fill_addr(input int k);
    if (k == 2 || k == 5) return LINE_A + AW'(k);
    return AW'((k + 1) << 6) + AW'(k);
  endfunction

  initial begin
    logic [AW-1:0] pool [4];
    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1040;
    pool[2] = 32'h0000_2000; pool[3] = LINE_A;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin m_done[i] = 0; m_tag[i] = 0; end
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(negedge clk); #1;
    check(alloc_ready == 1'b1 && alloc_idx == 3'd0, "R1 reset alloc", int'(alloc_idx), 0);
    check(!retire_valid && !clear, "R1 reset idle", int'(retire_valid) + int'(clear), 0);

    for (int k = 0; k < DEPTH; k++) step(1, fill_addr(k), 0, 0, 0, '0);
    idle();
    check(g_ready == 0, "R2 full stall", int'(g_ready), 0);

    step(0, '0, 1, 0, 0, '0);
    step(0, '0, 0, 0, 1, fill_addr(0) ^ 32'h1f);
    check(g_clear == 0 && g_retire == 1, "R6 head hit no clear", int'(g_clear), 0);

    step(0, '0, 1, 6, 1, fill_addr(6) ^ 32'h3);
    check(g_clear == 0, "R7 same-cycle completion", int'(g_clear), 0);

    step(0, '0, 0, 0, 1, fill_addr(3));
    check(g_clear == 0, "R10 incomplete match", int'(g_clear), 0);
    step(0, '0, 0, 0, 1, 32'h0009_0000);
    check(g_clear == 0, "R10 no match", int'(g_clear), 0);

    step(0, '0, 1, 2, 0, '0);
    step(0, '0, 1, 5, 0, '0);
    step(1, 32'h0000_7000, 1, 4, 1, LINE_A + 32'h2a);
    check(g_clear == 1 && g_cidx == 2, "R8 oldest violator", g_cidx, 2);
    check(g_ready == 0, "R9 no alloc on clear", int'(g_ready), 0);
    idle();
    check(g_aidx == 2, "R9 tail rewound", g_aidx, 2);
    step(0, '0, 1, 1, 0, '0);
    idle();
    check(g_retire == 1, "R3 head retires", int'(g_retire), 1);
    idle();
    check(g_retire == 0 && g_aidx == 2, "R9 younger discarded", int'(g_retire), 0);
    step(0, '0, 0, 0, 1, LINE_A);
    check(g_clear == 0, "R9 squashed lines gone", int'(g_clear), 0);
    step(0, '0, 1, 5, 0, '0);
    idle();
    check(g_retire == 0, "R3 completion of unheld index ignored", int'(g_retire), 0);

    for (int n = 0; n < 4000; n++) begin
      bit av, cv, sv;
      int ci, cnt;
      logic [AW-1:0] aa, sa;
      cnt = (m_tail - m_head) & 15;
      av = ($urandom % 10) < 6;
      cv = ($urandom % 10) < 5;
      sv = ($urandom % 10) < 3;
      aa = pool[$urandom % 4] + AW'($urandom % 64);
      sa = pool[$urandom % 4] + AW'($urandom % 64);
      if (cnt == 0 || ($urandom % 4) == 0) ci = int'($urandom % 8);
      else ci = (m_head + int'($urandom % cnt)) & 7;
      step(av, aa, cv, ci, sv, sa);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule